// File: doc/BRIEF.md
# Vectored Interrupt Controller Register Core

This block collects 64 level-driven interrupt sources and presents them to a processor as two requests: a normal request and a fast request. Each source has a pending bit, an enable bit and a type bit. The type bit routes the source to the fast request when it is 1 and to the normal request when it is 0. Every source also carries a 4-bit priority. A 5-bit threshold gates the normal request by priority, and one all-ones threshold value turns that gating off.

Software reaches the block through a word-addressed register port with separate read and write strobes. Reading one of the two vector registers returns the source to service and also acknowledges it: the reported source's pending bit is cleared in the same cycle. Two extra writes set or clear a single enable bit by source number, so software does not need a read-modify-write. A pair of force registers lets software overwrite pending state directly. The highest-priority normal source comes from a separate resolver module, and the lowest-numbered fast source comes from a scan module.

Top module: `vic_regcore`

## Requirements
- R1: After reset the threshold reads 0x1F, and pending, enable, type, control and all priority words read zero. Both requests are low.
- R2: Pending bit s is loaded from `src_level[s]` only in a cycle where that input differs from its value in the previous cycle. A force write or a vector-read clear in the same cycle is applied after the source change and therefore wins.
- R3: Offsets 4/5 are the enable upper/lower halves and offsets 6/7 are the type upper/lower halves; all four read back what was written. A write to offset 20 or 21 replaces the upper or lower pending half. Both force offsets read zero. Offsets 18/19 read the pending halves. Offsets 22/23 read the halves of pending & enable & ~type. Offsets 24/25 read the halves of pending & enable & type.
- R4: A write to offset 2 sets the enable bit numbered by `wdata[5:0]`. A write to offset 3 clears that bit. Both offsets read zero.
- R5: Offsets 8 to 15 hold priority words in reverse order: offset k holds word 15−k. Source s takes its priority from word s/8, bits [4·(s mod 8)+3 : 4·(s mod 8)].
- R6: `irq_fast` is high exactly when some source is pending, enabled and of fast type.
- R7: When the threshold is 0x1F, `irq_normal` is high when any pending, enabled, normal-type source exists. Otherwise `irq_normal` is high only when such a source has a priority strictly greater than the threshold.
- R8: A read of offset 16 returns the source number in bits [31:16] and its priority in bits [15:0]. The source chosen is the pending, enabled, normal-type source with the highest priority; among equal priorities the highest number wins. The read clears that source's pending bit. With no such source the read returns 0xFFFFFFFF.
- R9: A read of offset 17 returns the lowest-numbered pending, enabled, fast-type source, zero-extended, and clears its pending bit. With no such source the read returns 0xFFFFFFFF.
- R10: Writes to offsets 16 to 19 and 22 to 25 change no state. Offsets 26 to 63 read zero, and writes to them change no state.
- R11: Offset 0 is a control register: bits [15:0] are writable and bits [31:16] read zero. Offset 1 holds the threshold in bits [4:0].
- R12: `rdata` takes the value of a read on the clock edge that samples `rd_en`, and keeps it until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_level | input | 64 | Interrupt source levels |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 6 | Word offset |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| irq_normal | output | 1 | Normal interrupt request |
| irq_fast | output | 1 | Fast interrupt request |

## Verification
Normal-vector reads run on a priority set that contains a tie. This shows whether the highest number wins a tie, and whether each acknowledge exposes the next winner until the all-ones empty value appears. The threshold is swept through 0, a middle value, a value above every possible priority, and 0x1F. The sweep separates the strict-greater comparison from the bypass value. Fast reads on sources at both ends of the upper half confirm the lowest-first order. A source edge placed in the same cycle as a force write shows which of the two wins.

// File: rtl/vic_pkg.sv
`timescale 1ns/1ps
package vic_pkg;

    localparam int unsigned VIC_ADDR_W = 6;

    typedef enum logic [4:0] {
        REG_CTRL, REG_MASK, REG_ENNUM, REG_DISNUM,
        REG_ENHI, REG_ENLO, REG_TYHI, REG_TYLO,
        REG_PRIO, REG_NVEC, REG_FVEC, REG_SRCHI,
        REG_SRCLO, REG_FRCHI, REG_FRCLO, REG_NPHI,
        REG_NPLO, REG_FPHI, REG_FPLO, REG_NONE
    } vic_reg_e;

    function automatic vic_reg_e vic_decode(input logic [VIC_ADDR_W-1:0] a);
        vic_reg_e r;
        case (a)
            6'd0:  r = REG_CTRL;
            6'd1:  r = REG_MASK;
            6'd2:  r = REG_ENNUM;
            6'd3:  r = REG_DISNUM;
            6'd4:  r = REG_ENHI;
            6'd5:  r = REG_ENLO;
            6'd6:  r = REG_TYHI;
            6'd7:  r = REG_TYLO;
            6'd8, 6'd9, 6'd10, 6'd11,
            6'd12, 6'd13, 6'd14, 6'd15: r = REG_PRIO;
            6'd16: r = REG_NVEC;
            6'd17: r = REG_FVEC;
            6'd18: r = REG_SRCHI;
            6'd19: r = REG_SRCLO;
            6'd20: r = REG_FRCHI;
            6'd21: r = REG_FRCLO;
            6'd22: r = REG_NPHI;
            6'd23: r = REG_NPLO;
            6'd24: r = REG_FPHI;
            6'd25: r = REG_FPLO;
            default: r = REG_NONE;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/vic_prio_resolver.sv
`timescale 1ns/1ps
module vic_prio_resolver #(
    parameter int unsigned NUM_SRC = 64,
    parameter int unsigned PRIO_W  = 4,
    parameter int unsigned MASK_W  = 5,
    parameter int unsigned IDX_W   = $clog2(NUM_SRC)
) (
    input  logic [NUM_SRC-1:0]        req,
    input  logic [NUM_SRC*PRIO_W-1:0] prio_flat,
    input  logic [MASK_W-1:0]         thresh,
    output logic                      found,
    output logic [IDX_W-1:0]          win_idx,
    output logic [PRIO_W-1:0]         win_prio,
    output logic                      above
);
    // Ascending scan with >= so that a later (higher-numbered) source takes ties.
    always_comb begin
        found    = 1'b0;
        win_idx  = '0;
        win_prio = '0;
        above    = 1'b0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (req[i]) begin
                if (!found || prio_flat[i*PRIO_W +: PRIO_W] >= win_prio) begin
                    found    = 1'b1;
                    win_idx  = IDX_W'(i);
                    win_prio = prio_flat[i*PRIO_W +: PRIO_W];
                end
                if (MASK_W'(prio_flat[i*PRIO_W +: PRIO_W]) > thresh) begin
                    above = 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/vic_low_finder.sv
`timescale 1ns/1ps
module vic_low_finder #(
    parameter int unsigned NUM_SRC = 64,
    parameter int unsigned IDX_W   = $clog2(NUM_SRC)
) (
    input  logic [NUM_SRC-1:0] req,
    output logic               found,
    output logic [IDX_W-1:0]   idx
);
    // Descending scan: the last hit assigned is the lowest index.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (req[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/vic_regcore.sv
`timescale 1ns/1ps
module vic_regcore
    import vic_pkg::*;
#(
    parameter int unsigned NUM_SRC   = 64,
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned PRIO_W    = 4,
    parameter int unsigned MASK_W    = 5,
    parameter int unsigned CTRL_BITS = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_SRC-1:0]    src_level,
    input  logic                  wr_en,
    input  logic                  rd_en,
    input  logic [VIC_ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0]     wdata,
    output logic [DATA_W-1:0]     rdata,
    output logic                  irq_normal,
    output logic                  irq_fast
);
    localparam int unsigned IDX_W      = $clog2(NUM_SRC);
    localparam int unsigned HALF       = NUM_SRC / 2;
    localparam int unsigned PER_WORD   = DATA_W / PRIO_W;
    localparam int unsigned PRIO_WORDS = NUM_SRC / PER_WORD;
    localparam int unsigned PW_W       = $clog2(PRIO_WORDS);
    localparam int unsigned VEC_HALF   = DATA_W / 2;

    vic_reg_e sel;
    assign sel = vic_decode(addr);

    logic [NUM_SRC-1:0]   pend_q, pend_d, en_q, type_q, src_q, chg;
    logic [CTRL_BITS-1:0] ctrl_q;
    logic [MASK_W-1:0]    mask_q;
    logic [DATA_W-1:0]    prio_q [PRIO_WORDS];
    logic [DATA_W-1:0]    rdata_q, rd_mux;
    logic [PW_W-1:0]      pw_idx;

    // offset k selects word 15-k (reverse order)
    assign pw_idx = PW_W'(PRIO_WORDS - 1) - addr[PW_W-1:0];

    logic [NUM_SRC*PRIO_W-1:0] prio_flat;
    genvar s;
    generate
        for (s = 0; s < NUM_SRC; s++) begin : g_flat
            assign prio_flat[s*PRIO_W +: PRIO_W] = prio_q[s / PER_WORD][(s % PER_WORD)*PRIO_W +: PRIO_W];
        end
    endgenerate

    logic [NUM_SRC-1:0] norm_req, fast_req;
    assign norm_req = pend_q & en_q & ~type_q;
    assign fast_req = pend_q & en_q & type_q;

    logic              n_found, n_above, f_found;
    logic [IDX_W-1:0]  n_idx, f_idx;
    logic [PRIO_W-1:0] n_prio;

    vic_prio_resolver #(
        .NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .MASK_W(MASK_W), .IDX_W(IDX_W)
    ) u_resolver (
        .req(norm_req), .prio_flat(prio_flat), .thresh(mask_q),
        .found(n_found), .win_idx(n_idx), .win_prio(n_prio), .above(n_above)
    );

    vic_low_finder #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_fast_find (
        .req(fast_req), .found(f_found), .idx(f_idx)
    );

    assign irq_fast   = |fast_req;
    assign irq_normal = (mask_q == '1) ? (|norm_req) : n_above;

    // Pending next state: source edges first, then force writes, then read-acknowledge.
    assign chg = src_level ^ src_q;
    always_comb begin
        pend_d = (pend_q & ~chg) | (src_level & chg);
        if (wr_en) begin
            if (sel == REG_FRCHI) pend_d[NUM_SRC-1:HALF] = wdata;
            if (sel == REG_FRCLO) pend_d[HALF-1:0]       = wdata;
        end
        if (rd_en) begin
            if (sel == REG_NVEC && n_found) pend_d[n_idx] = 1'b0;
            if (sel == REG_FVEC && f_found) pend_d[f_idx] = 1'b0;
        end
    end

    always_comb begin
        unique case (sel)
            REG_CTRL:  rd_mux = DATA_W'(ctrl_q);
            REG_MASK:  rd_mux = DATA_W'(mask_q);
            REG_ENHI:  rd_mux = en_q[NUM_SRC-1:HALF];
            REG_ENLO:  rd_mux = en_q[HALF-1:0];
            REG_TYHI:  rd_mux = type_q[NUM_SRC-1:HALF];
            REG_TYLO:  rd_mux = type_q[HALF-1:0];
            REG_PRIO:  rd_mux = prio_q[pw_idx];
            REG_NVEC:  rd_mux = n_found ? {VEC_HALF'(n_idx), VEC_HALF'(n_prio)} : '1;
            REG_FVEC:  rd_mux = f_found ? DATA_W'(f_idx) : '1;
            REG_SRCHI: rd_mux = pend_q[NUM_SRC-1:HALF];
            REG_SRCLO: rd_mux = pend_q[HALF-1:0];
            REG_NPHI:  rd_mux = norm_req[NUM_SRC-1:HALF];
            REG_NPLO:  rd_mux = norm_req[HALF-1:0];
            REG_FPHI:  rd_mux = fast_req[NUM_SRC-1:HALF];
            REG_FPLO:  rd_mux = fast_req[HALF-1:0];
            default:   rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q  <= '0;
            src_q   <= '0;
            en_q    <= '0;
            type_q  <= '0;
            ctrl_q  <= '0;
            mask_q  <= '1;
            rdata_q <= '0;
            for (int w = 0; w < PRIO_WORDS; w++) prio_q[w] <= '0;
        end else begin
            pend_q <= pend_d;
            src_q  <= src_level;
            if (rd_en) rdata_q <= rd_mux;
            if (wr_en) begin
                unique case (sel)
                    REG_CTRL:   ctrl_q <= wdata[CTRL_BITS-1:0];
                    REG_MASK:   mask_q <= wdata[MASK_W-1:0];
                    REG_ENNUM:  en_q[wdata[IDX_W-1:0]] <= 1'b1;
                    REG_DISNUM: en_q[wdata[IDX_W-1:0]] <= 1'b0;
                    REG_ENHI:   en_q[NUM_SRC-1:HALF] <= wdata;
                    REG_ENLO:   en_q[HALF-1:0] <= wdata;
                    REG_TYHI:   type_q[NUM_SRC-1:HALF] <= wdata;
                    REG_TYLO:   type_q[HALF-1:0] <= wdata;
                    REG_PRIO:   prio_q[pw_idx] <= wdata;
                    default: ;
                endcase
            end
        end
    end

    assign rdata = rdata_q;

    assert_ennum_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == REG_ENNUM) |=> en_q[$past(wdata[IDX_W-1:0])]);

    assert_disnum_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == REG_DISNUM) |=> !en_q[$past(wdata[IDX_W-1:0])]);

    assert_normal_has_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_normal |-> (|norm_req));

    assert_winner_requesting_R8: assert property (@(posedge clk) disable iff (!rst_n)
        n_found |-> norm_req[n_idx]);

    assert_vector_reports_winner_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en && sel == REG_NVEC && n_found)
        |=> rdata[DATA_W-1:VEC_HALF] == VEC_HALF'($past(n_idx)));

    assert_fast_lowest_R9: assert property (@(posedge clk) disable iff (!rst_n)
        f_found |-> (fast_req[f_idx] && ((fast_req & ~({NUM_SRC{1'b1}} << f_idx)) == '0)));

endmodule

// File: tb/vic_regcore_tb.sv
`timescale 1ns/1ps
module vic_regcore_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] src_level = '0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [5:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq_normal, irq_fast;

    always #2 clk = ~clk;  // 250 MHz

    vic_regcore u_dut (
        .clk(clk), .rst_n(rst_n), .src_level(src_level), .wr_en(wr_en),
        .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata),
        .irq_normal(irq_normal), .irq_fast(irq_fast)
    );

    int    n_chk = 0, n_err = 0;
    bit    done = 1'b0;
    string cur_req = "R1";

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s act=%08h exp=%08h t=%0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference model
    logic [63:0] m_pend, m_en, m_type, m_srcq, np, nreq, freq;
    logic [31:0] m_prio [8];
    logic [4:0]  m_mask;
    logic [15:0] m_ctrl;
    logic [31:0] m_rd;

    function automatic int prio_of(input int src);
        return int'(m_prio[src / 8][4 * (src % 8) +: 4]);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_pend = '0; m_en = '0; m_type = '0; m_srcq = '0;
            m_mask = 5'h1f; m_ctrl = '0; m_rd = '0;
            for (int w = 0; w < 8; w++) m_prio[w] = '0;
        end else begin
            np = m_pend;
            for (int i = 0; i < 64; i++)
                if (src_level[i] !== m_srcq[i]) np[i] = src_level[i];
            m_srcq = src_level;
            nreq = m_pend & m_en & ~m_type;
            freq = m_pend & m_en & m_type;
            if (rd_en) begin
                case (addr)
                    0: m_rd = {16'h0, m_ctrl};
                    1: m_rd = {27'h0, m_mask};
                    4: m_rd = m_en[63:32];
                    5: m_rd = m_en[31:0];
                    6: m_rd = m_type[63:32];
                    7: m_rd = m_type[31:0];
                    8, 9, 10, 11, 12, 13, 14, 15: m_rd = m_prio[15 - int'(addr)];
                    16: begin
                        int best, bi;
                        best = -1; bi = -1;
                        for (int i = 63; i >= 0; i--)
                            if (nreq[i] && prio_of(i) > best) begin best = prio_of(i); bi = i; end
                        if (bi >= 0) begin m_rd = (bi << 16) | best; np[bi] = 1'b0; end
                        else m_rd = 32'hFFFF_FFFF;
                    end
                    17: begin
                        int bi;
                        bi = -1;
                        for (int i = 0; i < 64; i++)
                            if (freq[i] && bi < 0) bi = i;
                        if (bi >= 0) begin m_rd = bi; np[bi] = 1'b0; end
                        else m_rd = 32'hFFFF_FFFF;
                    end
                    18: m_rd = m_pend[63:32];
                    19: m_rd = m_pend[31:0];
                    22: m_rd = nreq[63:32];
                    23: m_rd = nreq[31:0];
                    24: m_rd = freq[63:32];
                    25: m_rd = freq[31:0];
                    default: m_rd = '0;
                endcase
            end
            if (wr_en) begin
                case (addr)
                    0: m_ctrl = wdata[15:0];
                    1: m_mask = wdata[4:0];
                    2: m_en[wdata[5:0]] = 1'b1;
                    3: m_en[wdata[5:0]] = 1'b0;
                    4: m_en[63:32] = wdata;
                    5: m_en[31:0] = wdata;
                    6: m_type[63:32] = wdata;
                    7: m_type[31:0] = wdata;
                    8, 9, 10, 11, 12, 13, 14, 15: m_prio[15 - int'(addr)] = wdata;
                    20: np[63:32] = wdata;
                    21: np[31:0] = wdata;
                    default: ;
                endcase
            end
            m_pend = np;
        end
    end

    // Per-clock comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            logic [63:0] nr;
            logic        en_norm;
            nr = m_pend & m_en & ~m_type;
            en_norm = 1'b0;
            if (m_mask == 5'h1f) en_norm = |nr;
            else for (int i = 0; i < 64; i++)
                if (nr[i] && prio_of(i) > int'(m_mask)) en_norm = 1'b1;
            chk("R6", {31'h0, irq_fast}, {31'h0, |(m_pend & m_en & m_type)});
            chk("R7", {31'h0, irq_normal}, {31'h0, en_norm});
            chk({cur_req, "/R12"}, rdata, m_rd);
        end
    end

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a);
        @(negedge clk); rd_en = 1'b1; addr = a;
        @(negedge clk); rd_en = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1", {30'h0, irq_normal, irq_fast}, 32'h0);
        chk("R1", rdata, 32'h0);
        rst_n = 1'b1;

        cur_req = "R1";
        for (int k = 0; k < 26; k++) rd(6'(k));

        cur_req = "R11";
        wr(0, 32'hDEAD_BEEF); rd(0);
        wr(1, 32'hFFFF_FFE3); rd(1);
        wr(1, 32'h5); rd(1);

        cur_req = "R4";
        wr(2, 5); wr(2, 40); wr(2, 32'h147);
        rd(5); rd(4);
        wr(3, 5); rd(5); rd(2); rd(3);

        cur_req = "R3";
        wr(4, 32'hF0F0_0001); wr(5, 32'h0000_FFFF);
        wr(6, 32'h0000_0001); wr(7, 32'h0000_00F0);
        for (int k = 4; k < 8; k++) rd(6'(k));
        wr(20, 32'h1234_0001); wr(21, 32'h8000_00F3);
        rd(20); rd(21);
        for (int k = 18; k < 26; k++) if (k != 20 && k != 21) rd(6'(k));

        cur_req = "R5";
        for (int k = 8; k < 16; k++) wr(6'(k), 32'h1357_9BDF ^ (32'h1111_1111 * k));
        for (int k = 8; k < 16; k++) rd(6'(k));

        cur_req = "R7";
        wr(1, 0); repeat (2) @(negedge clk);
        wr(1, 7); repeat (2) @(negedge clk);
        wr(1, 32'h10); repeat (2) @(negedge clk);
        wr(1, 32'h1F); repeat (2) @(negedge clk);

        cur_req = "R8";
        wr(21, 0); wr(20, 0);
        wr(5, 32'hFFFF_FFFF); wr(4, 32'hFFFF_FFFF);
        wr(7, 0); wr(6, 32'hFFFF_FFFF);
        wr(15, 32'h0000_9009); wr(14, 32'h0000_0050);
        wr(1, 8);
        wr(21, 32'h0000_0209);
        for (int k = 0; k < 4; k++) rd(16);
        wr(1, 32'h1F);

        cur_req = "R9";
        wr(20, 32'h8000_0011);
        for (int k = 0; k < 4; k++) rd(17);

        cur_req = "R2";
        @(negedge clk); src_level = 64'h0000_0001_0000_0004;
        repeat (2) @(negedge clk);
        rd(19); rd(18);
        rd(17); rd(18);
        repeat (3) @(negedge clk);
        rd(18);
        @(negedge clk); src_level[1] = 1'b1; wr_en = 1'b1; addr = 21; wdata = 0;
        @(negedge clk); wr_en = 1'b0;
        rd(19);
        @(negedge clk); src_level = '0;
        @(negedge clk); rd(19);

        cur_req = "R10";
        wr(21, 32'h0000_0F00);
        wr(16, 32'hFFFF_FFFF); wr(17, 32'hFFFF_FFFF);
        wr(18, 32'hFFFF_FFFF); wr(19, 32'hFFFF_FFFF);
        wr(22, 32'hFFFF_FFFF); wr(25, 32'hFFFF_FFFF);
        wr(30, 32'hFFFF_FFFF); wr(63, 32'hFFFF_FFFF);
        rd(19); rd(18); rd(5); rd(7); rd(30); rd(63);

        cur_req = "R12";
        rd(0);
        repeat (4) @(negedge clk);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_err++;
            $display("FAIL watchdog (all requirements) act=running exp=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule